// File: doc/BRIEF.md
# Two-Level Interleave Address Router

This block sits behind a fixed host memory window. It steers each access to one memory device among several. First it adds the window base to the window-relative request address, which gives a host physical address (HPA). The routing then takes two interleave stages. The window's own granularity and target count pick a host bridge. That bridge's decoder control word and its two packed target-list words then pick a downstream port number. The bridge index and the port number together give a flat device index. The response also carries the HPA, the size and the write data, so the chosen device can carry out the access.

When the decode finds no usable target, reads and writes are treated differently. A read completes with zero data and a poison error. A write is dropped with an OK response. A request moves in with a valid/ready handshake, and its decoded response is registered one cycle later. The response stays held until the consumer takes it. Accesses of 1 to 8 bytes at any alignment are routed on their starting address. An access that straddles an interleave boundary is not split.

Top module: `ilv_router`

## Requirements
- R1: `rsp_hpa` equals `req_addr + win_base`, taken modulo 2^ADDR_W.
- R2: The bridge index is (HPA >> (8 + `win_gran`)) modulo `win_ways`. A `win_ways` of 0, or one above NUM_HB, means no target. On a hit, `rsp_dev` = bridge × PORTS + port.
- R3: In a bridge control word, bits [3:0] hold the granularity encoding, bits [7:4] hold the ways encoding and bit 8 is the committed flag. If the committed flag is clear, the access has no target.
- R4: The list index is (HPA >> (8 + granularity encoding)) modulo 2^(ways encoding). A ways encoding above 3 means no target.
- R5: List indices 0–3 select byte `index` of the low target word, bits [8·i+7:8·i]. Indices 4–7 select byte `index−4` of the high target word. The selected byte is the port number.
- R6: A port number counts as a hit only when it is below PORTS and `port_present[bridge×PORTS+port]` is 1. Otherwise the access has no target.
- R7: A read with no target responds with `rsp_hit`=0, `rsp_err`=1 and `rsp_rdata`=0.
- R8: A write with no target responds with `rsp_hit`=0 and `rsp_err`=0, so it is dropped silently.
- R9: Sizes 1–8 bytes are routed at any address alignment. Any other size means no target. On a read hit, `rsp_rdata` is `dev_rdata` with every byte at or above the size set to zero, little-endian. On a write, `rsp_wdata` carries `req_wdata` with the same mask. On a read, `rsp_wdata` is 0.
- R10: `rsp_valid` is 1 in the cycle after a request is accepted. `req_ready` = !`rsp_valid` || `rsp_ready`. While the response is stalled, it holds steady.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Access size in bytes |
| req_addr | input | ADDR_W | Window-relative address |
| req_wdata | input | 64 | Write data, little-endian |
| win_base | input | ADDR_W | Window base address |
| win_gran | input | 4 | Window granularity encoding (256 << g bytes) |
| win_ways | input | HB_W+1 | Number of bridges in the window interleave |
| hb_ctrl | input | NUM_HB×9 | Per-bridge decoder control word |
| hb_tlo | input | NUM_HB×32 | Per-bridge target list, entries 0–3 |
| hb_thi | input | NUM_HB×32 | Per-bridge target list, entries 4–7 |
| port_present | input | NUM_HB×PORTS | Device attached behind each bridge port |
| dev_rdata | input | 64 | Read data returned by the selected device |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_valid | output | 1 | Response present |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_hit | output | 1 | A device was selected |
| rsp_err | output | 1 | Poison error (read with no target) |
| rsp_dev | output | DEV_W | Selected flat device index |
| rsp_hpa | output | ADDR_W | Host physical address |
| rsp_size | output | 4 | Access size |
| rsp_wdata | output | 64 | Masked write data |
| rsp_rdata | output | 64 | Masked read data |

## Verification
The properties assume the requester follows the handshake. They also assume the consumer drives `rsp_ready` as a plain level. The stimulus changes the window settings and bridge registers only at negative edges, between requests, so each decode sees one steady configuration. The random mix favours legal encodings and present ports, which keeps most accesses on the hit path. It still draws illegal sizes, ways encodings and absent ports often enough to reach every no-target branch.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    // Bit positions inside a bridge decoder control word
    localparam int CTRL_GRAN_LSB   = 0;
    localparam int CTRL_WAYS_LSB   = 4;
    localparam int CTRL_COMMIT_BIT = 8;
    localparam int CTRL_W          = CTRL_COMMIT_BIT + 1;
    localparam int ENC_W           = 4;

    // Granularity encoding g means 256 << g bytes
    localparam int GRAN_BASE_SHIFT = 8;

    localparam int BUS_BYTES = 8;
    localparam int BUS_W     = BUS_BYTES * 8;
    localparam int SIZE_W    = 4;
    localparam int TLIST_W   = 32;
    localparam int MAX_WAYS_ENC = 3;

    function automatic logic [BUS_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (i < int'(sz)) m[8*i +: 8] = 8'hFF;
        end
        return m;
    endfunction
endpackage

// File: rtl/ilv_bridge_sel.sv
module ilv_bridge_sel
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NUM_HB = 4,
    localparam int HB_W  = (NUM_HB > 1) ? $clog2(NUM_HB) : 1
) (
    input  logic [ADDR_W-1:0] hpa,
    input  logic [ENC_W-1:0]  gran,
    input  logic [HB_W:0]     ways,
    output logic [HB_W-1:0]   hb_idx,
    output logic              hb_ok
);
    logic [ADDR_W-1:0] chunk_d;
    logic [ADDR_W-1:0] rem_d;

    always_comb begin
        chunk_d = hpa >> (GRAN_BASE_SHIFT + int'(gran));
        hb_ok   = (ways != '0) && (ways <= (HB_W+1)'(NUM_HB));
        rem_d   = hb_ok ? (chunk_d % ADDR_W'(ways)) : '0;
        hb_idx  = rem_d[HB_W-1:0];
    end
endmodule

// File: rtl/ilv_port_sel.sv
module ilv_port_sel
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0]  hpa,
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic [TLIST_W-1:0] tlo,
    input  logic [TLIST_W-1:0] thi,
    output logic [7:0]         port,
    output logic               port_ok
);
    logic [ENC_W-1:0]   g_d;
    logic [ENC_W-1:0]   w_d;
    logic               commit_d;
    logic [2:0]         raw_d;
    logic [2:0]         idx_d;
    logic [TLIST_W-1:0] word_d;

    always_comb begin
        g_d      = ctrl[CTRL_GRAN_LSB +: ENC_W];
        w_d      = ctrl[CTRL_WAYS_LSB +: ENC_W];
        commit_d = ctrl[CTRL_COMMIT_BIT];
        raw_d    = 3'(hpa >> (GRAN_BASE_SHIFT + int'(g_d)));
        // Modulo 2^w: keep the low w bits (w = 3 wraps the mask to all ones)
        idx_d    = raw_d & ((3'd1 << w_d) - 3'd1);
        word_d   = idx_d[2] ? thi : tlo;
        port     = word_d[8*idx_d[1:0] +: 8];
        port_ok  = commit_d && (w_d <= ENC_W'(MAX_WAYS_ENC));
    end
endmodule

// File: rtl/ilv_router.sv
module ilv_router
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NUM_HB = 4,
    parameter int PORTS  = 4,
    localparam int HB_W  = (NUM_HB > 1) ? $clog2(NUM_HB) : 1,
    localparam int NDEV  = NUM_HB * PORTS,
    localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [SIZE_W-1:0]                 req_size,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [BUS_W-1:0]                  req_wdata,
    input  logic [ADDR_W-1:0]                 win_base,
    input  logic [ENC_W-1:0]                  win_gran,
    input  logic [HB_W:0]                     win_ways,
    input  logic [NUM_HB-1:0][CTRL_W-1:0]     hb_ctrl,
    input  logic [NUM_HB-1:0][TLIST_W-1:0]    hb_tlo,
    input  logic [NUM_HB-1:0][TLIST_W-1:0]    hb_thi,
    input  logic [NDEV-1:0]                   port_present,
    input  logic [BUS_W-1:0]                  dev_rdata,
    input  logic                              rsp_ready,
    output logic                              rsp_valid,
    output logic                              rsp_write,
    output logic                              rsp_hit,
    output logic                              rsp_err,
    output logic [DEV_W-1:0]                  rsp_dev,
    output logic [ADDR_W-1:0]                 rsp_hpa,
    output logic [SIZE_W-1:0]                 rsp_size,
    output logic [BUS_W-1:0]                  rsp_wdata,
    output logic [BUS_W-1:0]                  rsp_rdata
);
    typedef struct packed {
        logic              valid;
        logic              write;
        logic              hit;
        logic              err;
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] hpa;
        logic [SIZE_W-1:0] size;
        logic [BUS_W-1:0]  wdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [ADDR_W-1:0] hpa_d;
    logic [HB_W-1:0]   hb_idx_d;
    logic              hb_ok_d;
    logic [7:0]        port_d;
    logic              port_ok_d;
    logic              in_range_d;
    logic [DEV_W-1:0]  dev_d;
    logic              present_d;
    logic              size_ok_d;
    logic              hit_d;
    logic              accept_d;

    assign hpa_d = req_addr + win_base;

    // First stage: window interleave picks the host bridge
    ilv_bridge_sel #(.ADDR_W(ADDR_W), .NUM_HB(NUM_HB)) u_bridge (
        .hpa    (hpa_d),
        .gran   (win_gran),
        .ways   (win_ways),
        .hb_idx (hb_idx_d),
        .hb_ok  (hb_ok_d)
    );

    // Second stage: the chosen bridge's decoder picks the port
    ilv_port_sel #(.ADDR_W(ADDR_W)) u_port (
        .hpa     (hpa_d),
        .ctrl    (hb_ctrl[hb_idx_d]),
        .tlo     (hb_tlo[hb_idx_d]),
        .thi     (hb_thi[hb_idx_d]),
        .port    (port_d),
        .port_ok (port_ok_d)
    );

    always_comb begin
        req_ready  = !rsp_q.valid || rsp_ready;
        accept_d   = req_valid && req_ready;
        in_range_d = int'(port_d) < PORTS;
        dev_d      = in_range_d ? DEV_W'(int'(hb_idx_d) * PORTS + int'(port_d)) : '0;
        present_d  = in_range_d && port_present[dev_d];
        size_ok_d  = (req_size != '0) && (req_size <= SIZE_W'(BUS_BYTES));
        hit_d      = hb_ok_d && port_ok_d && present_d && size_ok_d;

        rsp_d = rsp_q;
        if (accept_d) begin
            rsp_d.valid = 1'b1;
            rsp_d.write = req_write;
            rsp_d.hit   = hit_d;
            rsp_d.err   = !hit_d && !req_write;
            rsp_d.dev   = hit_d ? dev_d : '0;
            rsp_d.hpa   = hpa_d;
            rsp_d.size  = req_size;
            rsp_d.wdata = req_write ? (req_wdata & size_mask(req_size)) : '0;
        end else if (rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    always_comb begin
        rsp_valid = rsp_q.valid;
        rsp_write = rsp_q.write;
        rsp_hit   = rsp_q.hit;
        rsp_err   = rsp_q.err;
        rsp_dev   = rsp_q.dev;
        rsp_hpa   = rsp_q.hpa;
        rsp_size  = rsp_q.size;
        rsp_wdata = rsp_q.wdata;
        rsp_rdata = (rsp_q.valid && rsp_q.hit && !rsp_q.write)
                    ? (dev_rdata & size_mask(rsp_q.size)) : '0;
    end
endmodule

// File: rtl/ilv_router_chk.sv
module ilv_router_chk #(
    parameter int ADDR_W = 48,
    parameter int DEV_W  = 4,
    parameter int BUS_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] win_base,
    input logic              rsp_ready,
    input logic              rsp_valid,
    input logic              rsp_write,
    input logic              rsp_hit,
    input logic              rsp_err,
    input logic [DEV_W-1:0]  rsp_dev,
    input logic [ADDR_W-1:0] rsp_hpa,
    input logic [BUS_W-1:0]  rsp_rdata
);
    // R1
    hpa_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_hpa == $past(req_addr + win_base)));

    // R10
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && rsp_write == $past(req_write)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hpa)
                                       && $stable(rsp_dev) && $stable(rsp_hit)));

    // R11
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    // R7
    read_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_write && !rsp_hit) |-> (rsp_err && rsp_rdata == '0));

    // R8
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_write) |-> !rsp_err);
endmodule

bind ilv_router ilv_router_chk #(
    .ADDR_W (ADDR_W),
    .DEV_W  (DEV_W),
    .BUS_W  (ilv_pkg::BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .win_base  (win_base),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_write (rsp_write),
    .rsp_hit   (rsp_hit),
    .rsp_err   (rsp_err),
    .rsp_dev   (rsp_dev),
    .rsp_hpa   (rsp_hpa),
    .rsp_rdata (rsp_rdata)
);

// File: tb/ilv_router_tb.sv
module ilv_router_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [3:0]        req_size = 4'd1;
    logic [47:0]       req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic [47:0]       win_base = '0;
    logic [3:0]        win_gran = '0;
    logic [2:0]        win_ways = 3'd1;
    logic [3:0][8:0]   hb_ctrl = '0;
    logic [3:0][31:0]  hb_tlo = '0;
    logic [3:0][31:0]  hb_thi = '0;
    logic [15:0]       port_present = '0;
    logic [63:0]       dev_rdata = '0;
    logic              rsp_ready = 1'b1;
    logic              rsp_valid, rsp_write, rsp_hit, rsp_err;
    logic [3:0]        rsp_dev;
    logic [47:0]       rsp_hpa;
    logic [3:0]        rsp_size;
    logic [63:0]       rsp_wdata, rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ilv_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .win_base(win_base), .win_gran(win_gran),
        .win_ways(win_ways), .hb_ctrl(hb_ctrl), .hb_tlo(hb_tlo), .hb_thi(hb_thi),
        .port_present(port_present), .dev_rdata(dev_rdata), .rsp_ready(rsp_ready),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .rsp_dev(rsp_dev), .rsp_hpa(rsp_hpa), .rsp_size(rsp_size),
        .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_of(input logic [3:0] sz);
        logic [63:0] m = '0;
        for (int i = 0; i < 8; i++) if (i < int'(sz)) m[8*i +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic void model(input logic [47:0] addr, input logic [3:0] sz,
                                  output logic [47:0] hpa, output logic hit,
                                  output logic [3:0] dev, output string why);
        logic [47:0] chunk;
        int hb, w, idx;
        logic [8:0] c;
        logic [7:0] port;
        hpa = addr + win_base; hit = 1'b0; dev = '0; why = "R6";
        if (sz == 0 || sz > 8) begin why = "R9"; return; end
        if (win_ways == 0 || win_ways > 4) begin why = "R2"; return; end
        chunk = hpa >> (8 + int'(win_gran));
        hb = int'(chunk % 48'(win_ways));
        c = hb_ctrl[hb];
        if (!c[8]) begin why = "R3"; return; end
        w = int'(c[7:4]);
        if (w > 3) begin why = "R4"; return; end
        idx = int'((hpa >> (8 + int'(c[3:0]))) % (48'd1 << w));
        port = (idx < 4) ? 8'(hb_tlo[hb] >> (8*idx)) : 8'(hb_thi[hb] >> (8*(idx-4)));
        if (port >= 8'd4 || !port_present[hb*4 + int'(port)]) begin why = "R6"; return; end
        hit = 1'b1; dev = 4'(hb*4 + int'(port)); why = "R5";
    endfunction

    task automatic txn(input logic [47:0] addr, input logic wr, input logic [3:0] sz,
                       input logic [63:0] wd);
        logic [47:0] e_hpa; logic e_hit; logic [3:0] e_dev; string why;
        logic [63:0] e_rd, e_wd;
        model(addr, sz, e_hpa, e_hit, e_dev, why);
        @(negedge clk);
        req_addr = addr; req_write = wr; req_size = sz; req_wdata = wd;
        req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        dev_rdata = {$urandom, $urandom};
        #1;
        e_rd = (!wr && e_hit) ? (dev_rdata & mask_of(sz)) : 64'd0;
        e_wd = wr ? (wd & mask_of(sz)) : 64'd0;
        chk(rsp_valid === 1'b1, "R10 latency", 64'(rsp_valid), 64'd1);
        chk(rsp_hpa === e_hpa, "R1 hpa", 64'(rsp_hpa), 64'(e_hpa));
        chk(rsp_hit === e_hit, {why, " hit"}, 64'(rsp_hit), 64'(e_hit));
        if (e_hit) chk(rsp_dev === e_dev, "R2 R5 dev", 64'(rsp_dev), 64'(e_dev));
        chk(rsp_err === (!e_hit && !wr), wr ? "R8 err" : "R7 err", 64'(rsp_err), 64'(!e_hit && !wr));
        chk(rsp_rdata === e_rd, e_hit ? "R9 rdata" : "R7 rdata", rsp_rdata, e_rd);
        chk(rsp_wdata === e_wd, "R9 wdata", rsp_wdata, e_wd);
    endtask

    task automatic cfg_plain();
        win_base = 48'h0; win_gran = 4'd0; win_ways = 3'd4;
        for (int h = 0; h < 4; h++) begin
            hb_ctrl[h] = {1'b1, 4'd2, 4'd0};
            hb_tlo[h]  = 32'h00010203;
            hb_thi[h]  = 32'h03020100;
        end
        port_present = 16'hFFFF;
    endtask

    task automatic cfg_random();
        win_base = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        win_gran = 4'($urandom_range(0, 3));
        win_ways = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(1, 4));
        for (int h = 0; h < 4; h++) begin
            hb_ctrl[h][8]   = ($urandom_range(0, 9) != 0);
            hb_ctrl[h][7:4] = ($urandom_range(0, 14) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
            hb_ctrl[h][3:0] = 4'($urandom_range(0, 3));
            for (int b = 0; b < 4; b++) begin
                hb_tlo[h][8*b +: 8] = 8'($urandom_range(0, 4));
                hb_thi[h][8*b +: 8] = 8'($urandom_range(0, 4));
            end
        end
        port_present = 16'($urandom) | 16'($urandom);
    endtask

    initial begin
        logic [47:0] held;
        void'($urandom(32'd20240613));
        cfg_plain();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11 reset state
        chk(rsp_valid === 1'b0, "R11 valid", 64'(rsp_valid), 64'd0);
        chk(req_ready === 1'b1, "R11 ready", 64'(req_ready), 64'd1);

        // R1 address wraps past the top
        win_base = 48'h200;
        txn(48'hFFFF_FFFF_FF00, 1'b0, 4'd8, 64'd0);
        // R2 three-way window, granularity 512 B
        cfg_plain(); win_ways = 3'd3; win_gran = 4'd1;
        txn(48'h0000_0000_0A00, 1'b0, 4'd4, 64'd0);
        // R2 zero ways means no target
        win_ways = 3'd0;
        txn(48'h100, 1'b0, 4'd2, 64'd0);
        // R3 uncommitted decoder
        cfg_plain();
        for (int h = 0; h < 4; h++) hb_ctrl[h][8] = 1'b0;
        txn(48'h4000, 1'b0, 4'd8, 64'd0);
        // R4 illegal ways encoding
        cfg_plain();
        for (int h = 0; h < 4; h++) hb_ctrl[h][7:4] = 4'd4;
        txn(48'h4000, 1'b0, 4'd8, 64'd0);
        // R5 eight-way list, index 5 from the high word
        cfg_plain(); win_ways = 3'd1;
        hb_ctrl[0] = {1'b1, 4'd3, 4'd0};
        hb_thi[0]  = 32'h00000200;
        txn(48'h0000_0000_0500, 1'b0, 4'd8, 64'd0);
        // R6 port out of range, then port absent
        hb_thi[0] = 32'h00000700;
        txn(48'h0500, 1'b0, 4'd8, 64'd0);
        hb_thi[0] = 32'h00000200; port_present[2] = 1'b0;
        txn(48'h0500, 1'b0, 4'd8, 64'd0);
        // R7 read miss, R8 write miss
        txn(48'h0500, 1'b0, 4'd3, 64'd0);
        txn(48'h0500, 1'b1, 4'd8, 64'hDEAD_BEEF_0123_4567);
        // R9 illegal sizes and an unaligned masked access
        cfg_plain();
        txn(48'h0105, 1'b0, 4'd0, 64'd0);
        txn(48'h0105, 1'b1, 4'd9, 64'h1122_3344_5566_7788);
        txn(48'h0105, 1'b0, 4'd3, 64'd0);
        txn(48'h0107, 1'b1, 4'd5, 64'h1122_3344_5566_7788);

        // R10 stall: response held, new request refused
        @(negedge clk);
        req_addr = 48'h1234; req_write = 1'b0; req_size = 4'd4;
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk); #1;
        chk(rsp_valid === 1'b1, "R10 stall valid", 64'(rsp_valid), 64'd1);
        chk(req_ready === 1'b0, "R10 stall ready", 64'(req_ready), 64'd0);
        held = rsp_hpa;
        req_addr = 48'h9999;
        @(negedge clk); #1;
        chk(rsp_hpa === held, "R10 hold hpa", 64'(rsp_hpa), 64'(held));
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk); #1;
        chk(rsp_valid === 1'b0, "R10 drain", 64'(rsp_valid), 64'd0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] sz;
            if (k % 8 == 0) cfg_random();
            sz = ($urandom_range(0, 11) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(1, 8));
            txn({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 1'($urandom), sz, {$urandom, $urandom});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule